// File: doc/BRIEF.md
# Chained Shift-Register Serial Driver

This block loads a whole frame of bytes in a single handshake and sends it bit by bit over three wires to a chain of latched shift registers. The wires are serial data, shift clock and latch clock. Each bit gets one shift-clock pulse. After the last bit of the last byte, one latch pulse makes every device in the chain update its parallel outputs at the same moment.

The frame width is a parameter, given as a count of bytes. Byte 0 goes out first and each byte is sent most significant bit first. So when the latch fires, byte 0 sits in the device farthest from the driver and the last byte sits in the nearest one. Every clock phase lasts a fixed number of system clocks, set by a parameter, so that slow devices are met.

A request is accepted only while the block is idle. At that moment the whole frame is copied in. Until `done` pulses, the block ignores both the frame input and any further requests.

Top module: `serialChainDriver`

## Requirements
- R1: Out of reset and whenever idle, `shiftClk` is 1, `latchClk` is 0, `busy` is 0 and `done` is 0.
- R2: A frame produces exactly 8*NUM_BYTES rising edges on `shiftClk`. The bits go out in this order: byte 0 (`frameData[7:0]`) bit 7 down to bit 0, then byte 1, and so on.
- R3: `serData` changes only while `shiftClk` is high. It holds steady for the whole low phase and across the rising edge that captures it.
- R4: Every low phase of `shiftClk` lasts exactly HALF_CYCLES system clocks. Every high phase inside a frame lasts at least HALF_CYCLES.
- R5: `latchClk` stays low while bits are being shifted. Each frame has exactly one latch pulse, which comes after the final shift-clock rise and stays high for exactly HALF_CYCLES clocks.
- R6: In a chain of NUM_BYTES devices, the byte sent first ends up latched in the farthest device and the byte sent last in the nearest one.
- R7: `busy` stays high for exactly 24*NUM_BYTES*HALF_CYCLES + 2*HALF_CYCLES clocks. `done` is high for exactly one clock: the first clock in which `busy` is low again, which is HALF_CYCLES clocks after the latch line returns low.
- R8: A request is accepted only while idle, and `frameData` is copied at that moment. Holding `startReq` high, or changing `frameData`, during a frame has no effect on the bits that are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Frame request; accepted when idle |
| frameData | input | 8*NUM_BYTES | Frame bytes; byte i at bits [8i+7:8i], byte 0 sent first |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock pulse when the frame is finished |
| serData | output | 1 | Serial data line |
| shiftClk | output | 1 | Shift clock line; rests high |
| latchClk | output | 1 | Latch clock line; rests low |

## Verification
Every pin is registered only through the controller state, so each line responds on the clock after the accepting edge. A bit's data is valid HALF_CYCLES clocks before its shift clock falls. The latch pulse starts right after the last high phase, and `done` follows HALF_CYCLES clocks after the latch pulse ends. Rather than sampling at fixed offsets, the bench watches the pins on every falling clock edge. It models the device chain from the shift-clock and latch edges it sees, and it measures run lengths and busy duration against these formulas. Per-frame checks are made only after `done` has been observed.

// File: rtl/sdrvPkg.sv
package sdrvPkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SLOW,
    ST_SHIGH,
    ST_LHIGH,
    ST_LLOW
  } phaseE;

  typedef struct packed {
    logic load;
    logic advance;
    logic sckLow;
    logic latchHigh;
  } strobeT;
endpackage

// File: rtl/sdrvCtrl.sv
module sdrvCtrl
  import sdrvPkg::*;
#(
  parameter int NUM_BYTES   = 3,
  parameter int HALF_CYCLES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   startReq,
  output strobeT strb,
  output logic   busy,
  output logic   done
);
  localparam int TOTAL_BITS = NUM_BYTES * 8;
  localparam int BIT_W      = $clog2(TOTAL_BITS);
  localparam int PH_W       = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;

  phaseE            state, nextState;
  logic [PH_W-1:0]  phaseCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             doneQ;
  logic             phaseEnd, lastBit, accept;

  assign phaseEnd = (phaseCnt == PH_W'(HALF_CYCLES - 1));
  assign lastBit  = (bitCnt == BIT_W'(TOTAL_BITS - 1));
  assign accept   = (state == ST_IDLE) && startReq;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:  if (startReq) nextState = ST_SETUP;
      ST_SETUP: if (phaseEnd) nextState = ST_SLOW;
      ST_SLOW:  if (phaseEnd) nextState = ST_SHIGH;
      ST_SHIGH: if (phaseEnd) nextState = lastBit ? ST_LHIGH : ST_SETUP;
      ST_LHIGH: if (phaseEnd) nextState = ST_LLOW;
      ST_LLOW:  if (phaseEnd) nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      bitCnt   <= '0;
      doneQ    <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE || nextState != state) phaseCnt <= '0;
      else                                       phaseCnt <= phaseCnt + 1'b1;
      if (accept)                                bitCnt <= '0;
      else if (state == ST_SHIGH && phaseEnd && !lastBit) bitCnt <= bitCnt + 1'b1;
      doneQ <= (state == ST_LLOW) && phaseEnd;
    end
  end

  always_comb begin
    strb.load      = accept;
    strb.advance   = (state == ST_SHIGH) && phaseEnd && !lastBit;
    strb.sckLow    = (state == ST_SLOW);
    strb.latchHigh = (state == ST_LHIGH);
  end

  assign busy = (state != ST_IDLE);
  assign done = doneQ;

  // R5: the latch phase is entered only from the last shift-high phase
  assert_latch_after_shift_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LHIGH && $past(state) != ST_LHIGH) |-> ($past(state) == ST_SHIGH && $past(lastBit)));

  // R4: a low phase past its first clock was preceded by low
  assert_low_width_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLOW && phaseCnt != '0) |-> ($past(state) == ST_SLOW));

  // R7: done lasts a single clock and never overlaps a frame
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (state != ST_SHIGH && state != ST_SLOW && state != ST_LHIGH));
endmodule

// File: rtl/sdrvData.sv
module sdrvData
  import sdrvPkg::*;
#(
  parameter int NUM_BYTES = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobeT                  strb,
  input  logic [NUM_BYTES*8-1:0]  frameData,
  output logic                    serData,
  output logic                    shiftClk,
  output logic                    latchClk
);
  localparam int TOTAL_BITS = NUM_BYTES * 8;

  logic [TOTAL_BITS-1:0] loadVec;
  logic [TOTAL_BITS-1:0] shiftReg;

  // byte 0 lands in the top byte so it leaves first, MSB first
  for (genvar i = 0; i < NUM_BYTES; i++) begin : gOrder
    assign loadVec[(NUM_BYTES-1-i)*8 +: 8] = frameData[i*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN)             shiftReg <= '0;
    else if (strb.load)    shiftReg <= loadVec;
    else if (strb.advance) shiftReg <= {shiftReg[TOTAL_BITS-2:0], 1'b0};
  end

  assign serData  = shiftReg[TOTAL_BITS-1];
  assign shiftClk = !strb.sckLow;
  assign latchClk = strb.latchHigh;

  // R3: data line does not move during a shift-clock low phase
  assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sckLow && $past(rstN)) |-> $stable(serData));

  // R8: frame contents change only on acceptance or bit advance
  assert_frame_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strb.load) && !$past(strb.advance) && $past(rstN)) |-> $stable(shiftReg));
endmodule

// File: rtl/serialChainDriver.sv
module serialChainDriver
  import sdrvPkg::*;
#(
  parameter int NUM_BYTES   = 3,
  parameter int HALF_CYCLES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startReq,
  input  logic [NUM_BYTES*8-1:0] frameData,
  output logic                   busy,
  output logic                   done,
  output logic                   serData,
  output logic                   shiftClk,
  output logic                   latchClk
);
  strobeT strb;

  sdrvCtrl #(.NUM_BYTES(NUM_BYTES), .HALF_CYCLES(HALF_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .strb(strb), .busy(busy), .done(done)
  );

  sdrvData #(.NUM_BYTES(NUM_BYTES)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .frameData(frameData),
    .serData(serData), .shiftClk(shiftClk), .latchClk(latchClk)
  );

  // R1: idle lines sit at their rest levels
  assert_idle_rest_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (shiftClk && !latchClk));
endmodule

// File: tb/serialChainDriver_test.sv
`timescale 1ns/1ps
module serialChainDriver_test;
  localparam int N = 3;
  localparam int H = 2;
  localparam int W = N * 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [W-1:0] frameData = '0;
  logic busy, done, serData, shiftClk, latchClk;

  int checks = 0;
  int fails = 0;

  serialChainDriver #(.NUM_BYTES(N), .HALF_CYCLES(H)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .frameData(frameData),
    .busy(busy), .done(done), .serData(serData), .shiftClk(shiftClk), .latchClk(latchClk)
  );

  always #10 clk = ~clk;

  // monitor state
  logic prevSck = 1'b1, prevLatch = 1'b0, prevData = 1'b0, prevBusy = 1'b0;
  logic [W-1:0] chainM = '0, latchedM = '0;
  int rises, latchPulses, lowRun, highRun, latchRun;
  int dataBad, widthBad, latchBad, busyCycles, doneCount, doneBad;

  task automatic clearMon();
    chainM = '0; latchedM = '0;
    rises = 0; latchPulses = 0; lowRun = 0; highRun = 0; latchRun = 0;
    dataBad = 0; widthBad = 0; latchBad = 0; busyCycles = 0; doneCount = 0; doneBad = 0;
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (!shiftClk && serData !== prevData) dataBad++;
      if (shiftClk && !prevSck) begin
        rises++;
        chainM = {chainM[W-2:0], serData};
        if (serData !== prevData) dataBad++;
        if (lowRun != H) widthBad++;
        highRun = 1;
      end else if (shiftClk) highRun++;
      if (!shiftClk && prevSck) begin
        if (highRun < H && rises > 0) widthBad++;
        lowRun = 1;
      end else if (!shiftClk) lowRun++;
      if (latchClk) begin
        latchRun++;
        if (rises != 8 * N) latchBad++;
      end
      if (latchClk && !prevLatch) begin
        latchPulses++;
        latchedM = chainM;
      end
      if (!latchClk && prevLatch) begin
        if (latchRun != H) latchBad++;
        latchRun = 0;
      end
      if (busy) busyCycles++;
      if (done) doneCount++;
      if (done && busy) doneBad++;
      if (prevBusy && !busy && !done) doneBad++;
      prevSck = shiftClk; prevLatch = latchClk; prevData = serData; prevBusy = busy;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] expChain(input logic [W-1:0] d);
    logic [W-1:0] r;
    for (int j = 0; j < N; j++) r[j*8 +: 8] = d[(N-1-j)*8 +: 8];
    return r;
  endfunction

  task automatic checkIdle(input string tag);
    @(negedge clk);
    check(shiftClk === 1'b1 && latchClk === 1'b0 && busy === 1'b0 && done === 1'b0,
          tag, {shiftClk, latchClk, busy, done}, 4'b1000);
  endtask

  task automatic runFrame(input logic [W-1:0] d, input bit disturb);
    logic [W-1:0] e;
    @(posedge clk); #1;
    clearMon();
    frameData = d;
    startReq = 1'b1;
    @(posedge clk); #1;
    if (disturb) begin
      frameData = ~d;                      // R8: must not reach the wires
      for (int k = 0; k < 40; k++) @(posedge clk);
      #1;
      frameData = d ^ {W{1'b1}};
    end
    startReq = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    e = expChain(d);
    check(rises == 8 * N, "R2 rise count", rises, 8 * N);
    check(latchedM == e, disturb ? "R8 captured frame" : "R2 bit order", latchedM, e);
    check(latchedM[(N-1)*8 +: 8] == d[7:0], "R6 farthest device", latchedM[(N-1)*8 +: 8], d[7:0]);
    check(dataBad == 0, "R3 data stability", dataBad, 0);
    check(widthBad == 0, "R4 phase widths", widthBad, 0);
    check(latchPulses == 1 && latchBad == 0, "R5 latch pulse", {latchPulses[31:0], latchBad[31:0]}, 64'h1_0000_0000);
    check(busyCycles == 24 * N * H + 2 * H, "R7 busy length", busyCycles, 24 * N * H + 2 * H);
    check(doneCount == 1 && doneBad == 0, "R7 done pulse", {doneCount[31:0], doneBad[31:0]}, 64'h1_0000_0000);
  endtask

  initial begin
    void'($urandom(32'd595));
    clearMon();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    checkIdle("R1 reset state");
    runFrame(24'h063F00, 1'b0);
    runFrame('0, 1'b0);
    runFrame({W{1'b1}}, 1'b0);
    runFrame(24'hA5C35A, 1'b0);
    runFrame(24'h800001, 1'b1);
    checkIdle("R1 idle between frames");
    for (int n = 0; n < 12; n++) begin
      logic [W-1:0] r;
      r = W'({$urandom(), $urandom()});
      runFrame(r, (n % 4) == 3);
    end
    checkIdle("R1 idle at end");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule